// File: doc/BRIEF.md
# Four-Channel Potentiometer Wiper Controller with I2C Slave

This block is the digital half of a four-channel digital potentiometer. An I2C master selects it by a 7-bit slave address. The upper four address bits are a fixed parameter, and the lower three come from strap pins, so up to eight parts can share one bus. Each channel has an 8-bit wiper code, which drives the analog tap decoder, and a shadow code that models non-volatile storage. When reset is released, the shadow codes are copied into the wiper codes, so every tap returns to its saved position.

A write transaction carries a command byte and then data bytes. The command byte selects a channel and chooses either the wiper code or the shadow code. Writing the shadow also moves the wiper. A read transaction returns the register that the last command byte selected. The block samples the bus with the system clock and drives SDA only by pulling it low. It has two resets. A soft reset clears the bus logic and re-runs the recall. A power-on reset also returns the shadow codes to their parameter defaults.

Top module: `i2c_pot_ctrl`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {ADDR_HI, strap[2:0]} (default ADDR_HI = 4'b0101). It acknowledges by pulling SDA low through the ninth SCL pulse. Bit 0 of the address byte is 0 for a write and 1 for a read.
- R2: On an address mismatch the block leaves SDA released during the ninth pulse. It ignores every further byte until the next START, and no wiper code changes.
- R3: SDA is sampled on SCL rising edges, and SDA is changed only after an SCL falling edge or a START/STOP. The sda_pull output set to 1 means pull low; set to 0 means released.
- R4: In the first byte after a write address, bit 7 set selects the shadow code and bit 7 clear selects the wiper code. Bits [1:0] select the channel. Bits [6:2] are ignored. The byte is acknowledged.
- R5: Each data byte after the command byte is acknowledged and written to the selected register. Further data bytes overwrite the same register.
- R6: A data byte written to a shadow code also updates that channel's wiper code in the same cycle.
- R7: A read returns the selected register, MSB first. If the master acknowledges the byte, the same byte is sent again. If the master does not acknowledge, SDA is released until the next START.
- R8: Channel i's wiper code appears on wiper_codes[8i+7:8i]. 00h is the low end and FFh the high end. A code changes only by a write or a recall.
- R9: One cycle after reset release, each wiper code equals its shadow code. A soft reset (rst_n) keeps the shadow codes. A power-on reset (por_n) restores NV_INIT (channel 0..3 = 20h, 40h, 80h, C0h).
- R10: A STOP or a repeated START ends the current transaction and releases SDA. A command byte alone changes only the read selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| por_n | input | 1 | Power-on reset, active low; also restores shadow codes |
| rst_n | input | 1 | Soft reset, active low; keeps shadow codes |
| strap | input | 3 | Low three bits of the slave address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| wiper_codes | output | 32 | Four 8-bit wiper codes, channel 0 in the low byte |

## Verification
The hardest case is the recall after a soft reset. Its result differs from a plain reset only when a shadow code holds a value other than its power-on default. The stimulus therefore first writes a shadow code over the bus and moves another wiper away from its default. It then pulses only rst_n and checks that each wiper follows its shadow, not zero or its old value. A power-on reset afterwards shows the shadow defaults returning. The repeated-START and command-only paths are reached by ending a write transaction early and then reading through the retained selection.

// File: rtl/i2c_pot_pkg.sv
package i2c_pot_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_CMD,
    ST_ACK_C,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_MACK
  } link_st_t;
endpackage

// File: rtl/i2c_pot_rstsync.sv
module i2c_pot_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= 2'b00;
    else         q <= {q[0], 1'b1};
  end

  assign rst_n_o = q[1];
endmodule

// File: rtl/i2c_pot_insync.sv
module i2c_pot_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  // the newest synchronized sample is index STAGES-1, the one before it is STAGES
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_q[STAGES-1] & ~scl_q[STAGES];
  assign scl_fall = ~scl_q[STAGES-1] & scl_q[STAGES];
  assign start_ev = scl_q[STAGES-1] & scl_q[STAGES] & ~sda_q[STAGES-1] & sda_q[STAGES];
  assign stop_ev  = scl_q[STAGES-1] & scl_q[STAGES] & sda_q[STAGES-1] & ~sda_q[STAGES];
endmodule

// File: rtl/i2c_pot_link.sv
module i2c_pot_link
  import i2c_pot_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          CHW     = 2,
  parameter logic [3:0]  ADDR_HI = 4'b0101
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_rise,
  input  logic           scl_fall,
  input  logic           start_ev,
  input  logic           stop_ev,
  input  logic           sda_s,
  input  logic [2:0]     strap,
  input  logic [DW-1:0]  rd_byte,
  output logic           sda_pull,
  output logic           sel_nv,
  output logic [CHW-1:0] sel_ch,
  output logic           wr_en,
  output logic [DW-1:0]  wr_data
);
  localparam int CNTW = $clog2(DW + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(DW);

  link_st_t       st, n_st;
  logic [CNTW-1:0] cnt, n_cnt;
  logic [DW-1:0]  sh, n_sh, tx, n_tx;
  logic           pull, n_pull, rw, n_rw, nack, n_nack;
  logic           n_sel_nv;
  logic [CHW-1:0] n_sel_ch;

  always_comb begin
    n_st     = st;
    n_cnt    = cnt;
    n_sh     = sh;
    n_tx     = tx;
    n_pull   = pull;
    n_rw     = rw;
    n_nack   = nack;
    n_sel_nv = sel_nv;
    n_sel_ch = sel_ch;
    wr_en    = 1'b0;
    if (stop_ev) begin
      n_st   = ST_IDLE;
      n_pull = 1'b0;
    end else if (start_ev) begin
      n_st   = ST_ADDR;
      n_cnt  = '0;
      n_pull = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise) begin
            n_sh  = {sh[DW-2:0], sda_s};
            n_cnt = cnt + 1'b1;
          end else if (scl_fall && cnt == LAST) begin
            n_pull = 1'b1;
            if (st == ST_ADDR) begin
              if (sh[DW-1:1] == {ADDR_HI, strap}) begin
                n_rw = sh[0];
                n_st = ST_ACK_A;
              end else begin
                n_pull = 1'b0;
                n_st   = ST_IDLE;
              end
            end else if (st == ST_CMD) begin
              n_sel_nv = sh[DW-1];
              n_sel_ch = sh[CHW-1:0];
              n_st     = ST_ACK_C;
            end else begin
              wr_en = 1'b1;
              n_st  = ST_ACK_W;
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            n_cnt = '0;
            if (rw) begin
              n_tx   = rd_byte;
              n_pull = ~rd_byte[DW-1];
              n_st   = ST_RD;
            end else begin
              n_pull = 1'b0;
              n_st   = ST_CMD;
            end
          end
        end
        ST_ACK_C, ST_ACK_W: begin
          if (scl_fall) begin
            n_pull = 1'b0;
            n_cnt  = '0;
            n_st   = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            n_cnt = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST) begin
              n_pull = 1'b0;
              n_st   = ST_MACK;
            end else begin
              n_tx   = {tx[DW-2:0], 1'b0};
              n_pull = ~tx[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            n_nack = sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              n_st = ST_IDLE;
            end else begin
              n_tx   = rd_byte;
              n_pull = ~rd_byte[DW-1];
              n_cnt  = '0;
              n_st   = ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      pull   <= 1'b0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      sel_nv <= 1'b0;
      sel_ch <= '0;
    end else begin
      st     <= n_st;
      cnt    <= n_cnt;
      sh     <= n_sh;
      tx     <= n_tx;
      pull   <= n_pull;
      rw     <= n_rw;
      nack   <= n_nack;
      sel_nv <= n_sel_nv;
      sel_ch <= n_sel_ch;
    end
  end

  assign sda_pull = pull;
  assign wr_data  = sh;
endmodule

// File: rtl/i2c_pot_regs.sv
module i2c_pot_regs #(
  parameter int                 NCH     = 4,
  parameter int                 DW      = 8,
  parameter int                 CHW     = 2,
  parameter logic [NCH*DW-1:0]  NV_INIT = '0
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              soft_rst_n,
  input  logic              wr_en,
  input  logic              wr_nv,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [DW-1:0]     wr_data,
  output logic              recall,
  output logic [NCH*DW-1:0] wiper_codes,
  output logic [NCH*DW-1:0] nv_codes
);
  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) recall <= 1'b1;
    else             recall <= 1'b0;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hit, nv_en, wip_en;
    logic [DW-1:0] wip_d;

    always_comb begin
      hit    = wr_en && (wr_ch == CHW'(i));
      nv_en  = hit && wr_nv;
      wip_en = hit || recall;
      wip_d  = recall ? nv_codes[i*DW +: DW] : wr_data;
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
      if (!por_rst_n)  nv_codes[i*DW +: DW] <= NV_INIT[i*DW +: DW];
      else if (nv_en)  nv_codes[i*DW +: DW] <= wr_data;
    end

    always_ff @(posedge clk or negedge soft_rst_n) begin
      if (!soft_rst_n)  wiper_codes[i*DW +: DW] <= '0;
      else if (wip_en)  wiper_codes[i*DW +: DW] <= wip_d;
    end
  end
endmodule

// File: rtl/i2c_pot_ctrl.sv
module i2c_pot_ctrl #(
  parameter int                NCH         = 4,
  parameter int                DW          = 8,
  parameter logic [3:0]        ADDR_HI     = 4'b0101,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NCH*DW-1:0] NV_INIT     = {8'hC0, 8'h80, 8'h40, 8'h20}
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [2:0]        strap,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic [NCH*DW-1:0] wiper_codes
);
  localparam int CHW = $clog2(NCH);

  logic              por_rst_n, soft_rst_n;
  logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              sel_nv, wr_en, recall;
  logic [CHW-1:0]    sel_ch;
  logic [DW-1:0]     wr_data, rd_byte;
  logic [NCH*DW-1:0] nv_codes;

  i2c_pot_rstsync u_por_sync  (.clk(clk), .arst_n(por_n),         .rst_n_o(por_rst_n));
  i2c_pot_rstsync u_soft_sync (.clk(clk), .arst_n(por_n & rst_n), .rst_n_o(soft_rst_n));

  i2c_pot_insync #(.STAGES(SYNC_STAGES)) u_insync (
    .clk(clk), .rst_n(soft_rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  always_comb begin
    rd_byte = sel_nv ? nv_codes[int'(sel_ch)*DW +: DW]
                     : wiper_codes[int'(sel_ch)*DW +: DW];
  end

  i2c_pot_link #(.DW(DW), .CHW(CHW), .ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(soft_rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_s(sda_s), .strap(strap), .rd_byte(rd_byte),
    .sda_pull(sda_pull), .sel_nv(sel_nv), .sel_ch(sel_ch),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  i2c_pot_regs #(.NCH(NCH), .DW(DW), .CHW(CHW), .NV_INIT(NV_INIT)) u_regs (
    .clk(clk), .por_rst_n(por_rst_n), .soft_rst_n(soft_rst_n),
    .wr_en(wr_en), .wr_nv(sel_nv), .wr_ch(sel_ch), .wr_data(wr_data),
    .recall(recall), .wiper_codes(wiper_codes), .nv_codes(nv_codes)
  );
endmodule

// File: rtl/i2c_pot_ctrl_chk.sv
module i2c_pot_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int CHW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              sda_pull,
  input logic              wr_en,
  input logic              wr_nv,
  input logic [CHW-1:0]    wr_ch,
  input logic [DW-1:0]     wr_data,
  input logic              recall,
  input logic [NCH*DW-1:0] wiper_codes,
  input logic [NCH*DW-1:0] nv_codes
);
  p_sda_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_ev || stop_ev));

  p_wiper_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wiper_codes[int'($past(wr_ch))*DW +: DW] == $past(wr_data));

  p_nv_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_nv) |=> nv_codes[int'($past(wr_ch))*DW +: DW] == $past(wr_data));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !recall) |=> $stable(wiper_codes));

  p_recall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recall |=> wiper_codes == $past(nv_codes));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull);
endmodule

bind i2c_pot_ctrl i2c_pot_ctrl_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(soft_rst_n), .scl_fall(scl_fall), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_pull(sda_pull), .wr_en(wr_en), .wr_nv(sel_nv),
  .wr_ch(sel_ch), .wr_data(wr_data), .recall(recall),
  .wiper_codes(wiper_codes), .nv_codes(nv_codes)
);

// File: tb/test_i2c_pot_ctrl.sv
module test_i2c_pot_ctrl;
  localparam int Q = 8;
  localparam logic [3:0] HI = 4'b0101;
  localparam logic [7:0] INIT [4] = '{8'h20, 8'h40, 8'h80, 8'hC0};

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic [2:0]  strap = 3'b010;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_pull;
  logic [31:0] wiper_codes;
  wire         sda_line = sda_m & ~sda_pull;

  int checks = 0, fails = 0;
  logic [7:0] m_wip [4];
  logic [7:0] m_nv  [4];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  i2c_pot_ctrl i_i2c_pot_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap(strap),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull), .wiper_codes(wiper_codes)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_wipers(input string req);
    for (int c = 0; c < 4; c++)
      chk(wiper_codes[c*8 +: 8] == m_wip[c], req, wiper_codes[c*8 +: 8], m_wip[c]);
  endtask

  // scoreboard monitor: compares read bytes against predicted bytes
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); nack = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl_m = 1'b0;
    end
    wq();
    send_bit(~mack);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] cmd, input logic [7:0] d, input string req);
    logic n;
    bus_start();
    wbyte({HI, a, 1'b0}, n); chk(n == 1'b0, "R1", n, 0);
    wbyte(cmd, n);           chk(n == 1'b0, "R4", n, 0);
    wbyte(d, n);             chk(n == 1'b0, req, n, 0);
    bus_stop();
    if (cmd[7]) m_nv[cmd[1:0]] = d;
    m_wip[cmd[1:0]] = d;
  endtask

  task automatic do_read(input logic [7:0] cmd, input bit twice, input string req);
    logic n;
    logic [7:0] b, e;
    bus_start();
    wbyte({HI, strap, 1'b0}, n); chk(n == 1'b0, "R1", n, 0);
    wbyte(cmd, n);               chk(n == 1'b0, "R4", n, 0);
    bus_start();
    wbyte({HI, strap, 1'b1}, n); chk(n == 1'b0, "R1", n, 0);
    e = cmd[7] ? m_nv[cmd[1:0]] : m_wip[cmd[1:0]];
    exp_q.push_back(e); tag_q.push_back(req);
    rbyte(twice, b); act_q.push_back(b);
    if (twice) begin
      exp_q.push_back(e); tag_q.push_back(req);
      rbyte(1'b0, b); act_q.push_back(b);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic n;
    logic [7:0] b;
    for (int c = 0; c < 4; c++) begin m_nv[c] = INIT[c]; m_wip[c] = INIT[c]; end
    repeat (5) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk_wipers("R9 power-up recall");
    chk(sda_pull == 1'b0, "R3 released at reset", sda_pull, 0);

    do_write(3'b010, 8'h02, 8'h5A, "R5");
    chk_wipers("R5 wiper write");
    do_read(8'h02, 1'b0, "R7 read wiper");

    do_write(3'b010, 8'h81, 8'h33, "R6");
    chk_wipers("R6 shadow write moves wiper");
    do_read(8'h81, 1'b0, "R6 read shadow");

    // address mismatch: NACK, following bytes ignored
    bus_start();
    wbyte({HI, 3'b011, 1'b0}, n); chk(n == 1'b1, "R2 nack on mismatch", n, 1);
    wbyte(8'h00, n); wbyte(8'hEE, n);
    bus_stop();
    chk_wipers("R2 ignored transfer");

    // several data bytes overwrite the same register
    bus_start();
    wbyte({HI, strap, 1'b0}, n); wbyte(8'h00, n);
    wbyte(8'h11, n); chk(n == 1'b0, "R5 ack data", n, 0);
    wbyte(8'h22, n); chk(n == 1'b0, "R5 ack data", n, 0);
    bus_stop();
    m_wip[0] = 8'h22;
    chk_wipers("R5 last byte wins");
    do_read(8'h00, 1'b1, "R7 repeated byte on master ack");

    // ignored command bits and code extremes
    do_write(3'b010, 8'h7F, 8'hFF, "R4");
    chk_wipers("R4 bits 6:2 ignored");
    do_write(3'b010, 8'h01, 8'h00, "R8");
    chk_wipers("R8 code extremes");

    // command byte alone: only selection changes
    bus_start();
    wbyte({HI, strap, 1'b0}, n); wbyte(8'h83, n);
    bus_stop();
    chk_wipers("R10 command only");
    bus_start();
    wbyte({HI, strap, 1'b1}, n); chk(n == 1'b0, "R1", n, 0);
    exp_q.push_back(m_nv[3]); tag_q.push_back("R10 retained selection");
    rbyte(1'b0, b); act_q.push_back(b);
    bus_stop();

    // repeated START abandons the first transaction
    bus_start();
    wbyte({HI, strap, 1'b0}, n); wbyte(8'h02, n);
    bus_start();
    wbyte({HI, strap, 1'b0}, n); wbyte(8'h00, n); wbyte(8'h77, n);
    bus_stop();
    m_wip[0] = 8'h77;
    chk_wipers("R10 repeated start");

    // strap change moves the address
    strap = 3'b101;
    do_write(3'b101, 8'h02, 8'hA5, "R1");
    chk_wipers("R1 new strap address");
    bus_start();
    wbyte({HI, 3'b010, 1'b0}, n); chk(n == 1'b1, "R1 old address rejected", n, 1);
    bus_stop();

    // soft reset: wipers follow retained shadows
    rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);
    for (int c = 0; c < 4; c++) m_wip[c] = m_nv[c];
    chk_wipers("R9 soft reset recall");

    // power-on reset: shadows back to defaults
    por_n = 1'b0; repeat (4) @(negedge clk); por_n = 1'b1;
    repeat (10) @(negedge clk);
    for (int c = 0; c < 4; c++) begin m_nv[c] = INIT[c]; m_wip[c] = INIT[c]; end
    chk_wipers("R9 power-on defaults");
    do_read(8'h81, 1'b0, "R9 shadow default");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule